// File: doc/BRIEF.md
# Multi-Level Capture Trigger Sequencer

This block watches a vector of sampled signals, one sample per clock, and decides for each sample whether it should be kept and when the capture trigger fires. It is built as a chain of programmable levels. Each level looks at the sample through a bank of shared match terms and follows one of five rules: count matches, count an unbroken run of matches, look for one event directly after another, look for two events spaced too closely, or simply wait a fixed number of samples. When a level's rule is met the sequencer moves to the next level, or, on the level marked as the trigger level, emits a single trigger pulse and settles into a final state in which it only keeps qualifying samples.

A level can also carry a fallback term with a target level. The fallback is looked at only when the level's own condition is false on that sample, and it sends the sequencer to the target level with fresh counters. A per-level qualifier chooses which samples are kept while that level is active.

Software fills in the terms and levels through a small write port while the sequencer is disarmed. Raising the arm input starts the search from level 0; dropping it clears all progress.

Top module: `capture_sequencer`

## Requirements
- R1: Term t (0..7) has a value word at address 2t (value in bits 15:0) and a mask word at address 2t+1 (mask in bits 15:0, invert flag in bit 31). The term is true when every sample bit selected by the mask equals the value bit, with the result inverted when the invert flag is set.
- R2: Level l (0..3) has a control word at address 16+2l and a limit word at 17+2l. Control word: bits 2:0 rule, bit 3 trigger-level flag, bits 5:4 keep qualifier, bits 7:6 fallback target, bits 15:8 term set A, bits 23:16 term set B, bits 31:24 fallback term set. Limit word: bits 15:0 limit N, bits 23:16 first-event term set. A set is true when any selected term is true. The level condition C is set A true and (set B empty or set B true).
- R3: Rule 0 (counting): each sample with C true adds one to the level count; samples with C false leave it unchanged; the level is met on the sample that brings the count to N (N of 0 acts as 1).
- R4: Rule 1 (run): as rule 0, but a sample with C false clears the count, so the level is met only after N consecutive samples with C true.
- R5: The fallback set is tested only on a sample where the level's own condition (C for rules 0 and 1, the met condition for rules 2 and 3) is false; when it is then true the sequencer goes to the fallback target level with all counts cleared. Rule 4 never takes the fallback.
- R6: Rule 2 (directly after): the level is met on a sample with C true when the sample just before it, taken at the same level, had the first-event set true.
- R7: Rule 3 (too close): after a sample with the first-event set true, the level is met on the first following sample with C true if fewer than N samples lie between the two. A C-true sample ends the window whether or not it fires; if it also matches the first event, a new window begins.
- R8: Rule 4, and rule codes 5 to 7 (delay): the level is met on its Nth sample (N of 0 acts as 1) regardless of the sample value.
- R9: Keep qualifier codes: 0 keep nothing, 1 keep every sample, 2 keep samples with C true, 3 keep samples with C false, judged at the level active for that sample. The keep output and the trigger output appear one clock after the sample.
- R10: When a level with the trigger flag set, or level 3, is met, the trigger output is high for exactly one clock; the sequencer then stays at that level for the rest of the armed period, fires no more, and keeps samples by that level's qualifier.
- R11: While arm is low all levels and counts are cleared and both outputs are low; the first sample after arm rises is evaluated at level 0.
- R12: Writes to the configuration have effect only while arm is low; a write while armed changes nothing, even after disarming.
- R13: After synchronous active-low reset all terms and levels are zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| arm | input | 1 | High to run the search, low to clear progress and allow writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| sig | input | 16 | Sampled signal vector |
| trig | output | 1 | One-clock trigger pulse |
| store_en | output | 1 | Keep flag for the sample of the previous clock |

## Verification
The hardest situations to reach from the ports are those where two rules meet on the same sample: a sample that satisfies both a level's own condition and its fallback, a sample that closes one too-close window and opens the next, and a configuration write landing while the search is in progress. Directed sequences place the sample values bit by bit to create each of these collisions, and long runs of random sample values, random level programs and randomly timed arm changes and writes then drive a behavioural model of the rules, compared with the outputs on every clock.

// File: rtl/cseq_pkg.sv
// Shared sizes, rule codes and the per-level configuration record.
// Assumes the packed control word fits in DATA_W bits.
package cseq_pkg;
    parameter int SIG_W      = 16;
    parameter int NUM_TERMS  = 8;
    parameter int NUM_LEVELS = 4;
    parameter int CNT_W      = 16;
    parameter int DATA_W     = 32;

    localparam int LVL_W    = $clog2(NUM_LEVELS);
    localparam int LVL_BASE = 2 * NUM_TERMS;
    localparam int ADDR_W   = $clog2(LVL_BASE + 2 * NUM_LEVELS);
    localparam int TGT_LO   = 6;
    localparam int AM_LO    = TGT_LO + LVL_W;
    localparam int BM_LO    = AM_LO + NUM_TERMS;
    localparam int EM_LO    = BM_LO + NUM_TERMS;

    localparam logic [2:0] RULE_COUNT   = 3'd0;
    localparam logic [2:0] RULE_RUN     = 3'd1;
    localparam logic [2:0] RULE_AFTER   = 3'd2;
    localparam logic [2:0] RULE_TOOCLOSE = 3'd3;

    typedef enum logic [1:0] {
        KEEP_NONE = 2'd0,
        KEEP_ALL  = 2'd1,
        KEEP_HIT  = 2'd2,
        KEEP_MISS = 2'd3
    } keep_e;

    typedef struct packed {
        logic [NUM_TERMS-1:0] fb_set;
        logic [NUM_TERMS-1:0] b_set;
        logic [NUM_TERMS-1:0] a_set;
        logic [LVL_W-1:0]     fb_tgt;
        logic [1:0]           keep;
        logic                 is_trig;
        logic [2:0]           rule;
        logic [NUM_TERMS-1:0] ev1_set;
        logic [CNT_W-1:0]     limit;
    } lvl_cfg_t;
endpackage

// File: rtl/cseq_term_bank.sv
// Bank of value/mask/invert match terms over the sample vector.
// Assumes wr_ok is already blocked while the sequencer is armed.
module cseq_term_bank
    import cseq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_ok,
    input  logic [ADDR_W-1:0]    cfg_addr,
    input  logic [DATA_W-1:0]    cfg_wdata,
    input  logic [SIG_W-1:0]     sig,
    output logic [NUM_TERMS-1:0] term_hit
);
    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
        logic [SIG_W-1:0] val_q;
        logic [SIG_W-1:0] msk_q;
        logic             inv_q;

        // Load the value word or the mask/invert word of this term.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                val_q <= '0;
                msk_q <= '0;
                inv_q <= 1'b0;
            end else if (wr_ok && cfg_addr == ADDR_W'(2 * t)) begin
                val_q <= cfg_wdata[SIG_W-1:0];
            end else if (wr_ok && cfg_addr == ADDR_W'(2 * t + 1)) begin
                msk_q <= cfg_wdata[SIG_W-1:0];
                inv_q <= cfg_wdata[DATA_W-1];
            end
        end

        // Compare the masked sample bits and apply the invert flag.
        assign term_hit[t] = (((sig ^ val_q) & msk_q) == '0) ^ inv_q;
    end
endmodule

// File: rtl/cseq_level_bank.sv
// Configuration registers of every level, unpacked into records.
// Assumes the word layout given by the offsets in cseq_pkg.
module cseq_level_bank
    import cseq_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           locked,
    input  logic                           cfg_we,
    input  logic [ADDR_W-1:0]              cfg_addr,
    input  logic [DATA_W-1:0]              cfg_wdata,
    output lvl_cfg_t [NUM_LEVELS-1:0]      lvl_cfg
);
    logic wr_ok;
    assign wr_ok = cfg_we && !locked;

    for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_lvl
        lvl_cfg_t q;

        // Load the control word or the limit word of this level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_ok && cfg_addr == ADDR_W'(LVL_BASE + 2 * l)) begin
                q.rule    <= cfg_wdata[2:0];
                q.is_trig <= cfg_wdata[3];
                q.keep    <= cfg_wdata[5:4];
                q.fb_tgt  <= cfg_wdata[TGT_LO +: LVL_W];
                q.a_set   <= cfg_wdata[AM_LO +: NUM_TERMS];
                q.b_set   <= cfg_wdata[BM_LO +: NUM_TERMS];
                q.fb_set  <= cfg_wdata[EM_LO +: NUM_TERMS];
            end else if (wr_ok && cfg_addr == ADDR_W'(LVL_BASE + 2 * l + 1)) begin
                q.limit   <= cfg_wdata[CNT_W-1:0];
                q.ev1_set <= cfg_wdata[CNT_W +: NUM_TERMS];
            end
        end

        assign lvl_cfg[l] = q;
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && rst_n) |=> $stable(lvl_cfg)) else $error("level config changed while armed"); // R12
endmodule

// File: rtl/cseq_engine.sv
// Level-walking state machine: applies the active level's rule to
// the term results, takes advance, fallback or trigger decisions and
// registers the trigger and keep outputs. Assumes the configuration
// is stable while arm is high.
module cseq_engine
    import cseq_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       arm,
    input  logic [NUM_TERMS-1:0]       term_hit,
    input  lvl_cfg_t [NUM_LEVELS-1:0]  lvl_cfg,
    output logic                       trig,
    output logic                       store_en
);
    logic [LVL_W-1:0] level;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] gap;
    logic             prev_ev1;
    logic             seen;
    logic             done;

    logic [LVL_W-1:0] n_level;
    logic [CNT_W-1:0] n_cnt;
    logic [CNT_W-1:0] n_gap;
    logic             n_prev, n_seen, n_done, fire;

    lvl_cfg_t         cur;
    logic             c_hit, ev1_hit, fb_hit, met, main_ok, keep_now;
    logic [CNT_W-1:0] lim;
    logic [CNT_W:0]   cnt_inc;
    logic             reach;

    assign cur     = lvl_cfg[level];
    assign c_hit   = (|(cur.a_set & term_hit)) &&
                     ((cur.b_set == '0) || (|(cur.b_set & term_hit)));
    assign ev1_hit = |(cur.ev1_set & term_hit);
    assign fb_hit  = |(cur.fb_set & term_hit);
    assign lim     = (cur.limit == '0) ? CNT_W'(1) : cur.limit;
    assign cnt_inc = {1'b0, cnt} + 1'b1;
    assign reach   = cnt_inc >= {1'b0, lim};

    // Choose whether the current sample is kept at this level.
    always_comb begin
        case (keep_e'(cur.keep))
            KEEP_ALL:  keep_now = 1'b1;
            KEEP_HIT:  keep_now = c_hit;
            KEEP_MISS: keep_now = !c_hit;
            default:   keep_now = 1'b0;
        endcase
    end

    // Apply the level rule, then the advance/trigger or fallback step.
    always_comb begin
        n_level = level;
        n_cnt   = cnt;
        n_gap   = gap;
        n_prev  = prev_ev1;
        n_seen  = seen;
        n_done  = done;
        fire    = 1'b0;
        met     = 1'b0;
        main_ok = 1'b0;
        if (!done) begin
            case (cur.rule)
                RULE_COUNT: begin
                    main_ok = c_hit;
                    if (c_hit) begin
                        n_cnt = cnt_inc[CNT_W-1:0];
                        met   = reach;
                    end
                end
                RULE_RUN: begin
                    main_ok = c_hit;
                    if (c_hit) begin
                        n_cnt = cnt_inc[CNT_W-1:0];
                        met   = reach;
                    end else begin
                        n_cnt = '0;
                    end
                end
                RULE_AFTER: begin
                    met     = c_hit && prev_ev1;
                    main_ok = met;
                    n_prev  = ev1_hit;
                end
                RULE_TOOCLOSE: begin
                    if (seen && c_hit) begin
                        met    = gap < cur.limit;
                        n_seen = ev1_hit;
                        n_gap  = '0;
                    end else if (ev1_hit) begin
                        n_seen = 1'b1;
                        n_gap  = '0;
                    end else if (seen && gap != '1) begin
                        n_gap  = gap + 1'b1;
                    end
                    main_ok = met;
                end
                default: begin
                    main_ok = 1'b1;
                    n_cnt   = cnt_inc[CNT_W-1:0];
                    met     = reach;
                end
            endcase

            if (met) begin
                if (cur.is_trig || level == LVL_W'(NUM_LEVELS - 1)) begin
                    fire   = 1'b1;
                    n_done = 1'b1;
                end else begin
                    n_level = level + 1'b1;
                end
                n_cnt  = '0;
                n_gap  = '0;
                n_prev = 1'b0;
                n_seen = 1'b0;
            end else if (!main_ok && fb_hit) begin
                n_level = cur.fb_tgt;
                n_cnt   = '0;
                n_gap   = '0;
                n_prev  = 1'b0;
                n_seen  = 1'b0;
            end
        end
    end

    // Hold progress cleared while disarmed, otherwise step each sample.
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) begin
            level    <= '0;
            cnt      <= '0;
            gap      <= '0;
            prev_ev1 <= 1'b0;
            seen     <= 1'b0;
            done     <= 1'b0;
            trig     <= 1'b0;
            store_en <= 1'b0;
        end else begin
            level    <= n_level;
            cnt      <= n_cnt;
            gap      <= n_gap;
            prev_ev1 <= n_prev;
            seen     <= n_seen;
            done     <= n_done;
            trig     <= fire;
            store_en <= keep_now;
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig) else $error("trigger longer than one clock"); // R10
    AST_FINAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && arm && done) |=> (done && $stable(level))) else $error("left final state while armed"); // R10
    AST_DISARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !arm) |=> (!trig && !store_en)) else $error("output while disarmed"); // R11
    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (arm && !done) |-> (cnt < lim)) else $error("count passed its limit"); // R3
endmodule

// File: rtl/capture_sequencer.sv
// Top of the capture trigger sequencer: term bank, level registers
// and the level engine. Assumes one sample per clock on sig.
module capture_sequencer
    import cseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [SIG_W-1:0]  sig,
    output logic              trig,
    output logic              store_en
);
    logic [NUM_TERMS-1:0]      term_hit;
    lvl_cfg_t [NUM_LEVELS-1:0] lvl_cfg;
    logic                      wr_ok;

    assign wr_ok = cfg_we && !arm;

    cseq_term_bank u_terms (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ok     (wr_ok),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .sig       (sig),
        .term_hit  (term_hit)
    );

    cseq_level_bank u_levels (
        .clk       (clk),
        .rst_n     (rst_n),
        .locked    (arm),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .lvl_cfg   (lvl_cfg)
    );

    cseq_engine u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .term_hit (term_hit),
        .lvl_cfg  (lvl_cfg),
        .trig     (trig),
        .store_en (store_en)
    );
endmodule

// File: tb/capture_sequencer_tb_top.sv
// Bench: behavioural model of the level rules, compared every clock,
// plus directed trigger counts and keep checks.
module capture_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        arm = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [15:0] sig = '0;
    logic        trig, store_en;

    int n_cmp = 0;
    int n_bad = 0;
    int ntrig = 0;
    bit finished = 0;
    string cur_req = "R13";

    always #10 clk = ~clk;

    capture_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .arm(arm), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .sig(sig),
        .trig(trig), .store_en(store_en)
    );

    // ---------------- reference model ----------------
    logic [15:0] tv [8];
    logic [15:0] tm [8];
    logic        tn [8];
    logic [31:0] lw0 [4];
    logic [31:0] lw1 [4];
    int m_lvl, m_cnt, m_gap;
    bit m_prev, m_seen, m_done;
    bit exp_trig = 0, exp_store = 0;

    task automatic m_clear();
        m_cnt = 0; m_gap = 0; m_prev = 0; m_seen = 0;
    endtask

    task automatic m_step();
        logic [31:0] w0, w1;
        logic [7:0] tmv;
        bit c, e1, fb, st, hit, mainv;
        int lim;
        w0 = lw0[m_lvl];
        w1 = lw1[m_lvl];
        for (int t = 0; t < 8; t++)
            tmv[t] = ((((sig ^ tv[t]) & tm[t]) == 16'h0) ? 1'b1 : 1'b0) ^ tn[t];
        c   = (|(w0[15:8] & tmv)) && ((w0[23:16] == 8'h0) || (|(w0[23:16] & tmv)));
        e1  = |(w1[23:16] & tmv);
        fb  = |(w0[31:24] & tmv);
        lim = (w1[15:0] == 0) ? 1 : int'(w1[15:0]);
        case (w0[5:4])
            2'd0: st = 0;
            2'd1: st = 1;
            2'd2: st = c;
            default: st = !c;
        endcase
        exp_store = st;
        exp_trig  = 0;
        if (!m_done) begin
            hit = 0; mainv = 0;
            case (w0[2:0])
                3'd0: begin mainv = c; if (c) begin m_cnt++; hit = (m_cnt >= lim); end end
                3'd1: begin mainv = c; if (c) begin m_cnt++; hit = (m_cnt >= lim); end else m_cnt = 0; end
                3'd2: begin hit = c && m_prev; mainv = hit; m_prev = e1; end
                3'd3: begin
                    if (m_seen && c) begin hit = (m_gap < int'(w1[15:0])); m_seen = e1; m_gap = 0; end
                    else if (e1) begin m_seen = 1; m_gap = 0; end
                    else if (m_seen && m_gap < 65535) m_gap++;
                    mainv = hit;
                end
                default: begin mainv = 1; m_cnt++; hit = (m_cnt >= lim); end
            endcase
            if (hit) begin
                if (w0[3] || m_lvl == 3) begin exp_trig = 1; m_done = 1; end
                else m_lvl++;
                m_clear();
            end else if (!mainv && fb) begin
                m_lvl = int'(w0[7:6]);
                m_clear();
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < 8; t++) begin tv[t] = 0; tm[t] = 0; tn[t] = 0; end
            for (int l = 0; l < 4; l++) begin lw0[l] = 0; lw1[l] = 0; end
            m_lvl = 0; m_done = 0; m_clear();
            exp_trig = 0; exp_store = 0;
        end else begin
            if (!arm) begin
                m_lvl = 0; m_done = 0; m_clear();
                exp_trig = 0; exp_store = 0;
            end else begin
                m_step();
            end
            if (cfg_we && !arm) begin
                if (cfg_addr < 16) begin
                    if (cfg_addr[0] == 1'b0) tv[cfg_addr >> 1] = cfg_wdata[15:0];
                    else begin tm[cfg_addr >> 1] = cfg_wdata[15:0]; tn[cfg_addr >> 1] = cfg_wdata[31]; end
                end else if (cfg_addr < 24) begin
                    if (cfg_addr[0] == 1'b0) lw0[(cfg_addr - 16) >> 1] = cfg_wdata;
                    else lw1[(cfg_addr - 16) >> 1] = cfg_wdata;
                end
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(string req, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(cur_req, "trig", int'(trig), int'(exp_trig));
            chk(cur_req, "store_en", int'(store_en), int'(exp_store));
            if (trig === 1'b1) ntrig++;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic wr(int a, logic [31:0] d);
        tick();
        cfg_we = 1; cfg_addr = 5'(a); cfg_wdata = d;
        tick();
        cfg_we = 0;
    endtask

    task automatic set_term(int t, logic [15:0] v, logic [15:0] m, bit inv);
        wr(2 * t, {16'h0, v});
        wr(2 * t + 1, {inv, 15'h0, m});
    endtask

    function automatic logic [31:0] ctl(int rule, bit trg, int keep, int tgt,
                                        logic [7:0] a, logic [7:0] b, logic [7:0] fb);
        return {fb, b, a, 2'(tgt), 2'(keep), trg, 3'(rule)};
    endfunction

    task automatic set_lvl(int l, logic [31:0] c, int lim, logic [7:0] e1);
        wr(16 + 2 * l, c);
        wr(17 + 2 * l, {8'h0, e1, 16'(lim)});
    endtask

    task automatic clear_levels();
        for (int l = 0; l < 4; l++) set_lvl(l, 32'h0, 0, 8'h0);
    endtask

    task automatic bit_terms();
        for (int t = 0; t < 4; t++) set_term(t, 16'(1 << t), 16'(1 << t), 0);
    endtask

    task automatic step(logic [15:0] s);
        tick();
        sig = s;
    endtask

    task automatic go();
        tick(); arm = 1; ntrig = 0;
    endtask

    task automatic stop_run();
        step(0); step(0); step(0);
        tick(); arm = 0;
    endtask

    // ---------------- scenarios ----------------
    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        tick();
        chk("R13", "trig after reset", int'(trig), 0);
        chk("R13", "store_en after reset", int'(store_en), 0);

        // R1 R3: counting, non-consecutive
        cur_req = "R3";
        bit_terms();
        set_lvl(0, ctl(0, 1, 1, 0, 8'h01, 8'h00, 8'h00), 3, 8'h00);
        go();
        step(1); step(0); step(1); step(0); step(1); step(0); step(0);
        step(0);
        chk("R3", "trigger count", ntrig, 1);
        chk("R10", "keep in final state", int'(store_en), 1);
        stop_run();

        // R4: run of consecutive matches
        cur_req = "R4";
        set_lvl(0, ctl(1, 1, 1, 0, 8'h01, 8'h00, 8'h00), 3, 8'h00);
        go();
        step(1); step(1); step(0); step(1); step(1); step(0);
        step(0);
        chk("R4", "no trigger on broken runs", ntrig, 0);
        step(1); step(1); step(1);
        stop_run();
        chk("R4", "trigger count", ntrig, 1);

        // R5: fallback only when own condition false
        cur_req = "R5";
        set_lvl(0, ctl(0, 0, 1, 0, 8'h01, 8'h00, 8'h00), 1, 8'h00);
        set_lvl(1, ctl(0, 1, 1, 0, 8'h04, 8'h00, 8'h02), 2, 8'h00);
        go();
        step(1); step(6); step(2); step(4); step(1); step(4); step(4);
        stop_run();
        chk("R5", "trigger count", ntrig, 1);
        go();
        step(1); step(4); step(2); step(4);
        stop_run();
        chk("R5", "fallback clears count", ntrig, 0);

        // R1 R2: value match, invert and AND of term sets
        cur_req = "R2";
        clear_levels();
        set_term(0, 16'h0A51, 16'hFFFF, 0);
        set_term(3, 16'h0008, 16'h0008, 1);
        set_lvl(0, ctl(0, 1, 2, 0, 8'h01, 8'h08, 8'h00), 1, 8'h00);
        go();
        step(16'h1A51); step(16'h0A50); step(16'h0A59);
        stop_run();
        chk("R1", "no match on wrong values", ntrig, 0);
        set_term(0, 16'h0A59, 16'hFFFF, 0);
        go();
        step(16'h0A59);
        stop_run();
        chk("R2", "inverted set B blocks", ntrig, 0);
        set_term(0, 16'h0A51, 16'hFFFF, 0);
        go();
        step(16'h0A51);
        stop_run();
        chk("R2", "trigger on AND of sets", ntrig, 1);

        // R6: directly after
        cur_req = "R6";
        bit_terms();
        set_lvl(0, ctl(2, 1, 1, 0, 8'h04, 8'h00, 8'h00), 0, 8'h02);
        go();
        step(2); step(0); step(4); step(4);
        step(0);
        chk("R6", "no trigger with gap", ntrig, 0);
        step(2); step(4);
        stop_run();
        chk("R6", "trigger count", ntrig, 1);

        // R7: too close
        cur_req = "R7";
        set_lvl(0, ctl(3, 1, 1, 0, 8'h04, 8'h00, 8'h00), 2, 8'h02);
        go();
        step(2); step(0); step(0); step(4);
        step(0);
        chk("R7", "two between is not too close", ntrig, 0);
        step(2); step(0); step(4);
        stop_run();
        chk("R7", "one between fires", ntrig, 1);
        go();
        step(2); step(0); step(0); step(6); step(4);
        stop_run();
        chk("R7", "closing sample reopens window", ntrig, 1);

        // R8: delay level
        cur_req = "R8";
        set_lvl(0, ctl(4, 0, 0, 0, 8'h00, 8'h00, 8'hFF), 3, 8'h00);
        set_lvl(1, ctl(0, 1, 0, 0, 8'h01, 8'h00, 8'h00), 1, 8'h00);
        go();
        step(1); step(1); step(1);
        step(0);
        chk("R8", "no trigger inside delay", ntrig, 0);
        step(1);
        stop_run();
        chk("R8", "trigger after delay", ntrig, 1);

        // R10: last level triggers without flag, only once
        cur_req = "R10";
        set_lvl(0, ctl(0, 0, 0, 0, 8'h01, 8'h00, 8'h00), 1, 8'h00);
        set_lvl(1, ctl(0, 0, 0, 0, 8'h02, 8'h00, 8'h00), 1, 8'h00);
        set_lvl(2, ctl(0, 0, 0, 0, 8'h04, 8'h00, 8'h00), 1, 8'h00);
        set_lvl(3, ctl(0, 0, 1, 0, 8'h08, 8'h00, 8'h00), 1, 8'h00);
        go();
        step(1); step(2); step(4); step(8); step(1); step(2); step(4); step(8);
        stop_run();
        chk("R10", "single trigger at last level", ntrig, 1);

        // R9: keep qualifiers
        cur_req = "R9";
        clear_levels();
        set_lvl(0, ctl(0, 0, 2, 0, 8'h01, 8'h00, 8'h00), 9, 8'h00);
        go();
        step(1); step(0);
        chk("R9", "keep on hit", int'(store_en), 1);
        step(0);
        chk("R9", "no keep on miss", int'(store_en), 0);
        stop_run();
        set_lvl(0, ctl(0, 0, 3, 0, 8'h01, 8'h00, 8'h00), 9, 8'h00);
        go();
        step(1); step(0);
        chk("R9", "inverse keep on hit", int'(store_en), 0);
        step(0);
        chk("R9", "inverse keep on miss", int'(store_en), 1);
        stop_run();

        // R12: writes while armed ignored
        cur_req = "R12";
        set_lvl(0, ctl(0, 1, 0, 0, 8'h01, 8'h00, 8'h00), 1, 8'h00);
        go();
        wr(16, ctl(0, 1, 0, 0, 8'h02, 8'h00, 8'h00));
        step(2); step(1);
        stop_run();
        chk("R12", "old config used while armed", ntrig, 1);
        go();
        step(2); step(0); step(1);
        stop_run();
        chk("R12", "old config kept after disarm", ntrig, 1);

        // R11: disarm clears progress
        cur_req = "R11";
        set_lvl(0, ctl(0, 1, 1, 0, 8'h01, 8'h00, 8'h00), 2, 8'h00);
        go();
        step(1);
        tick(); arm = 0;
        tick();
        chk("R11", "keep low while disarmed", int'(store_en), 0);
        arm = 1; sig = 1;
        step(0);
        chk("R11", "count restarted", ntrig, 0);
        step(1);
        stop_run();
        chk("R11", "trigger after restart", ntrig, 1);

        // Random programs against the model
        cur_req = "R5";
        for (int r = 0; r < 20; r++) begin
            for (int t = 0; t < 8; t++)
                set_term(t, 16'($urandom & 32'hF), 16'($urandom & 32'hF), 1'($urandom & 1));
            for (int l = 0; l < 4; l++)
                set_lvl(l, ctl($urandom % 6, 1'($urandom % 3 == 0), $urandom % 4, $urandom % 4,
                               8'($urandom), 8'($urandom % 4 == 0 ? 0 : $urandom), 8'($urandom & 32'h33)),
                        $urandom % 5, 8'($urandom));
            go();
            for (int k = 0; k < 200; k++) begin
                tick();
                sig = 16'($urandom);
                if ($urandom % 64 == 0) arm = !arm;
                cfg_we = ($urandom % 16 == 0);
                cfg_addr = 5'($urandom % 24);
                cfg_wdata = $urandom;
            end
            tick(); cfg_we = 0; arm = 0;
        end

        tick();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule